// File: doc/BRIEF.md
# Sequenced Time-Stamp Register Port

This block is a byte-wide register window that sits on a CPU-style peripheral bus. It covers 24 consecutive byte addresses starting at 0x2188. Most of these addresses are plain read/write configuration bytes. A few of them have side effects: one folds two registers into each other, one forces a status byte, and one masks some bits on readback. One address is a data port. Each read of that port returns the next byte of a fixed cyclic frame, and the frame carries a time stamp.

The time of day arrives on three binary byte inputs: hour, minute and second. The block samples them only when the port is read at the first position of the frame. Every later byte of that frame uses the sampled copy, so a frame never mixes two times. A write to the link register at 0x2191 moves the frame back to its start. Any address the block does not return data for yields the bus-supplied open-bus byte. Every read result is registered.

Top module: `ts_regport`

## Requirements
- R1: After reset every register and the frame position are zero, and `rdata` is 0x00.
- R2: Offsets 0x2188, 0x2189, 0x218A, 0x218C, 0x218E, 0x2194, 0x2197 and 0x2199 store the written byte and read it back unchanged. The offsets 0x218B and 0x2191 store a written byte but never return it.
- R3: A read returns the `open_bus` byte sampled with the strobe in two cases: the address lies outside 0x2188..0x219F, or it is one of 0x218B, 0x218D, 0x2191, 0x2195, 0x2198 or 0x219A..0x219F.
- R4: Read data appears on `rdata` exactly one clock after the `rd_en` cycle. `rdata` keeps its value in cycles without a read.
- R5: Each read of 0x2192 returns the byte at the current frame position and then advances the position by one. After position 17 it returns to 0, giving an 18-byte frame. Reads of other addresses leave the position alone.
- R6: Frame positions 5 and 6 read 0x01. Position 10 reads the second, 11 the minute and 12 the hour. All other positions read 0x00.
- R7: A read at frame position 0 captures `hour`, `minute` and `second` in the same cycle. Positions 10 to 12 of that frame return the captured values even if the inputs change later.
- R8: A write to 0x2191 stores the data and returns the frame position to 0.
- R9: A write to 0x2192 stores nothing and does not move the frame. It sets the status byte read at 0x2190 to 0x80.
- R10: A read of 0x2193 returns the stored byte with bits 3 and 2 cleared.
- R11: A write to 0x218F ignores its data. Let F be the byte at 0x218F and E the byte at 0x218E. The write sets 0x218E to (F - (E >> 1)) mod 256 and 0x218F to F >> 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 16 | Byte address |
| rd_en | input | 1 | Read strobe, one cycle per access |
| wr_en | input | 1 | Write strobe, one cycle per access |
| wdata | input | 8 | Write data |
| hour | input | 8 | Binary hour, 0 to 23 |
| minute | input | 8 | Binary minute, 0 to 59 |
| second | input | 8 | Binary second, 0 to 59 |
| open_bus | input | 8 | Byte returned for addresses without read data |
| rdata | output | 8 | Registered read data |

## Verification
Every read result is due on `rdata` one clock after its strobe. The bench drives each strobe on a falling edge and samples the result on the following falling edge, after the single register stage has loaded. Write side effects take effect at the strobe's rising edge, so the earliest read that can observe them is the next access. The frame position, the time capture and the status byte are therefore always checked through a later read. The time inputs are sampled at the strobe edge, so the bench fixes them before the strobe and changes them only afterwards to prove they were held.

// File: rtl/ts_pkg.sv
// Shared constants and helpers for the time-stamp register port.
// Assumes an 8-bit data path and a 24-byte window; the offsets below
// are behavioural (side effects hang off them) and must not move.
package ts_pkg;

    localparam int DW = 8;

    // Offsets inside the window
    localparam int OFS_STAT = 8;   // status byte, forced by a port write
    localparam int OFS_LINK = 9;   // write rewinds the frame
    localparam int OFS_PORT = 10;  // sequenced data port
    localparam int OFS_CTRL = 11;  // readback masked
    localparam int OFS_ACC  = 6;   // fold target
    localparam int OFS_FOLD = 7;   // fold trigger

    localparam logic [DW-1:0] CTRL_MASK = 8'h0C;
    localparam logic [DW-1:0] STAT_SET  = 8'h80;

    // Frame positions carrying non-zero content
    localparam int FR_ONE_A = 5;
    localparam int FR_ONE_B = 6;
    localparam int FR_SEC   = 10;
    localparam int FR_MIN   = 11;
    localparam int FR_HR    = 12;

    typedef struct packed {
        logic [DW-1:0] hr;
        logic [DW-1:0] mn;
        logic [DW-1:0] sc;
    } tod_t;

    // Offsets that store written data plainly
    function automatic bit is_stored(input int off);
        case (off)
            0, 1, 2, 3, 4, 9, 11, 12, 15, 17: return 1'b1;
            default:                          return 1'b0;
        endcase
    endfunction

    // Offsets that return their register contents directly
    function automatic bit is_readable(input int off);
        case (off)
            0, 1, 2, 4, 6, 7, 8, 12, 14, 15, 17: return 1'b1;
            default:                             return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/ts_reg_bank.sv
// Register storage for the window. One generate branch per offset picks
// plain storage, the status byte, the fold pair or no storage at all.
// Assumes at most one write per cycle, already qualified by the window.
module ts_reg_bank
    import ts_pkg::*;
#(
    parameter int WIN = 24,
    localparam int OW = $clog2(WIN)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_stb,
    input  logic [OW-1:0] wr_off,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rf [WIN]
);

    for (genvar g = 0; g < WIN; g++) begin : g_reg
        localparam logic [OW-1:0] ME = OW'(g);
        if (g == OFS_STAT) begin : g_stat
            // Status byte: set by a write to the data port
            always_ff @(posedge clk) begin
                if (!rst_n)                                   rf[g] <= '0;
                else if (wr_stb && wr_off == OW'(OFS_PORT))   rf[g] <= STAT_SET;
            end
        end else if (g == OFS_ACC) begin : g_acc
            // Fold target: plain write or folded from the trigger register
            always_ff @(posedge clk) begin
                if (!rst_n)                                   rf[g] <= '0;
                else if (wr_stb && wr_off == ME)              rf[g] <= wdata;
                else if (wr_stb && wr_off == OW'(OFS_FOLD))
                    rf[g] <= rf[OFS_FOLD] - (rf[g] >> 1);
            end
        end else if (g == OFS_FOLD) begin : g_fold
            // Fold trigger: data ignored, own value halves
            always_ff @(posedge clk) begin
                if (!rst_n)                                   rf[g] <= '0;
                else if (wr_stb && wr_off == ME)              rf[g] <= rf[g] >> 1;
            end
        end else if (is_stored(g)) begin : g_plain
            // Plain configuration byte
            always_ff @(posedge clk) begin
                if (!rst_n)                                   rf[g] <= '0;
                else if (wr_stb && wr_off == ME)              rf[g] <= wdata;
            end
        end else begin : g_none
            assign rf[g] = '0;
        end
    end

endmodule

// File: rtl/ts_frame_seq.sv
// Frame sequencer for the data port: holds the position, captures the
// time of day at position 0 and forms the byte for the current position.
// Assumes rewind and step are never wanted together; rewind wins.
module ts_frame_seq
    import ts_pkg::*;
#(
    parameter int FRAME_LEN = 18,
    localparam int IW = $clog2(FRAME_LEN)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  logic          rewind,
    input  tod_t          tod_in,
    output logic [IW-1:0] idx,
    output logic [DW-1:0] frame_byte
);

    localparam logic [IW-1:0] LAST = IW'(FRAME_LEN - 1);

    tod_t held;

    // Position counter: rewind, or advance once per port read
    always_ff @(posedge clk) begin
        if (!rst_n)      idx <= '0;
        else if (rewind) idx <= '0;
        else if (step)   idx <= (idx == LAST) ? '0 : idx + 1'b1;
    end

    // Time holding registers, loaded on the first read of a frame
    always_ff @(posedge clk) begin
        if (!rst_n)                  held <= '0;
        else if (step && idx == '0)  held <= tod_in;
    end

    // Content of the current position
    always_comb begin
        case (int'(idx))
            FR_ONE_A, FR_ONE_B: frame_byte = 8'h01;
            FR_SEC:             frame_byte = held.sc;
            FR_MIN:             frame_byte = held.mn;
            FR_HR:              frame_byte = held.hr;
            default:            frame_byte = 8'h00;
        endcase
    end

endmodule

// File: rtl/ts_rd_mux.sv
// Read path: selects the addressed byte, applies the readback mask and
// falls back to open bus, then registers the result for one-cycle latency.
module ts_rd_mux
    import ts_pkg::*;
#(
    parameter int WIN = 24,
    localparam int OW = $clog2(WIN)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_stb,
    input  logic          in_win,
    input  logic [OW-1:0] off,
    input  logic [DW-1:0] rf [WIN],
    input  logic [DW-1:0] frame_byte,
    input  logic [DW-1:0] open_bus,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] sel;

    // Byte selection by offset
    always_comb begin
        sel = open_bus;
        if (in_win) begin
            for (int i = 0; i < WIN; i++) begin
                if (off == OW'(i)) begin
                    if (i == OFS_PORT)      sel = frame_byte;
                    else if (i == OFS_CTRL) sel = rf[i] & ~CTRL_MASK;
                    else if (is_readable(i)) sel = rf[i];
                end
            end
        end
    end

    // Output register, loaded only on a read strobe
    always_ff @(posedge clk) begin
        if (!rst_n)      rdata <= '0;
        else if (rd_stb) rdata <= sel;
    end

endmodule

// File: rtl/ts_regport.sv
// Top of the time-stamp register port: decodes the window, drives the
// register bank, the frame sequencer and the registered read path.
// Assumes rd_en and wr_en are never high in the same cycle.
module ts_regport
    import ts_pkg::*;
#(
    parameter int          ADDR_W    = 16,
    parameter logic [15:0] BASE_ADDR = 16'h2188,
    parameter int          FRAME_LEN = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [7:0]        wdata,
    input  logic [7:0]        hour,
    input  logic [7:0]        minute,
    input  logic [7:0]        second,
    input  logic [7:0]        open_bus,
    output logic [7:0]        rdata
);

    localparam int WIN = 24;
    localparam int OW  = $clog2(WIN);
    localparam int IW  = $clog2(FRAME_LEN);

    logic [ADDR_W-1:0] rel;
    logic              in_win;
    logic [OW-1:0]     off;
    logic [DW-1:0]     rf [WIN];
    logic [IW-1:0]     frame_idx;
    logic [DW-1:0]     frame_byte;
    tod_t              tod_in;

    // Window decode
    assign rel    = addr - ADDR_W'(BASE_ADDR);
    assign in_win = (addr >= ADDR_W'(BASE_ADDR)) && (rel < ADDR_W'(WIN));
    assign off    = rel[OW-1:0];
    assign tod_in = '{hr: hour, mn: minute, sc: second};

    ts_reg_bank #(.WIN(WIN)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_stb (wr_en && in_win),
        .wr_off (off),
        .wdata  (wdata),
        .rf     (rf)
    );

    ts_frame_seq #(.FRAME_LEN(FRAME_LEN)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .step       (rd_en && in_win && off == OW'(OFS_PORT)),
        .rewind     (wr_en && in_win && off == OW'(OFS_LINK)),
        .tod_in     (tod_in),
        .idx        (frame_idx),
        .frame_byte (frame_byte)
    );

    ts_rd_mux #(.WIN(WIN)) u_rd (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_stb     (rd_en),
        .in_win     (in_win),
        .off        (off),
        .rf         (rf),
        .frame_byte (frame_byte),
        .open_bus   (open_bus),
        .rdata      (rdata)
    );

endmodule

// File: rtl/ts_regport_chk.sv
// Property checker for ts_regport, attached by bind. Observes the ports
// and the frame position exported by the sequencer.
module ts_regport_chk #(
    parameter int          ADDR_W    = 16,
    parameter logic [15:0] BASE_ADDR = 16'h2188,
    parameter int          FRAME_LEN = 18,
    localparam int         IW        = $clog2(FRAME_LEN)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              rd_en,
    input logic              wr_en,
    input logic [7:0]        rdata,
    input logic [7:0]        open_bus,
    input logic [IW-1:0]     frame_idx
);

    localparam logic [IW-1:0]     LAST      = IW'(FRAME_LEN - 1);
    localparam logic [ADDR_W-1:0] PORT_ADDR = ADDR_W'(BASE_ADDR) + ADDR_W'(10);
    localparam logic [ADDR_W-1:0] LINK_ADDR = ADDR_W'(BASE_ADDR) + ADDR_W'(9);
    localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(BASE_ADDR) + ADDR_W'(11);

    logic outside;
    logic [IW-1:0] idx_next;
    assign outside  = (addr < ADDR_W'(BASE_ADDR)) || (addr > ADDR_W'(BASE_ADDR) + ADDR_W'(23));
    assign idx_next = (frame_idx == LAST) ? '0 : frame_idx + 1'b1;

    // R1: output is cleared while reset is held
    a_r1_reset_clear: assert property (@(posedge clk) !rst_n |=> rdata == 8'h00);

    // R4: no strobe, no change
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));

    // R3: outside the window the open-bus byte comes back
    a_r3_outside: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && outside) |=> rdata == $past(open_bus));

    // R5: one step per port read, wrapping after the last position
    a_r5_step: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && addr == PORT_ADDR) |=> frame_idx == $past(idx_next));

    // R5: other reads do not move the frame
    a_r5_still: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && addr != PORT_ADDR) |=> $stable(frame_idx));

    // R8: link write rewinds
    a_r8_rewind: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == LINK_ADDR) |=> frame_idx == '0);

    // R10: masked bits never read as one
    a_r10_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == CTRL_ADDR) |=> rdata[3:2] == 2'b00);

    // R6: constant frame positions
    a_r6_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == PORT_ADDR && (frame_idx == IW'(5) || frame_idx == IW'(6)))
        |=> rdata == 8'h01);

endmodule

bind ts_regport ts_regport_chk #(
    .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .FRAME_LEN(FRAME_LEN)
) u_chk (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
    .rdata(rdata), .open_bus(open_bus), .frame_idx(frame_idx)
);

// File: tb/sim_ts_regport.sv
module sim_ts_regport;

    localparam logic [15:0] BASE = 16'h2188;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr = '0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wdata = '0;
    logic [7:0]  hour = '0, minute = '0, second = '0;
    logic [7:0]  open_bus = '0;
    logic [7:0]  rdata;

    int n_chk = 0;
    int n_fail = 0;

    // Bench model of the requirements
    logic [7:0] m [24];
    int         midx = 0;
    logic [7:0] mh = 0, mm = 0, ms = 0;

    ts_regport u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
        .wdata(wdata), .hour(hour), .minute(minute), .second(second),
        .open_bus(open_bus), .rdata(rdata)
    );

    always #4 clk = ~clk;

    function automatic bit f_readable(input int o);
        return o inside {0, 1, 2, 4, 6, 7, 8, 12, 14, 15, 17};
    endfunction

    function automatic bit f_stored(input int o);
        return o inside {0, 1, 2, 3, 4, 6, 9, 11, 12, 15, 17};
    endfunction

    function automatic logic [7:0] f_frame(input int i);
        case (i)
            5, 6:    return 8'h01;
            10:      return ms;
            11:      return mm;
            12:      return mh;
            default: return 8'h00;
        endcase
    endfunction

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    // Model of one read, updates frame state (R3, R5, R6, R7, R10)
    task automatic m_read(input logic [15:0] a, output logic [7:0] e);
        int o;
        if (a < BASE || a > BASE + 16'd23) begin
            e = open_bus;
            return;
        end
        o = int'(a - BASE);
        if (o == 10) begin
            if (midx == 0) begin
                mh = hour; mm = minute; ms = second;
            end
            e = f_frame(midx);
            midx = (midx == 17) ? 0 : midx + 1;
        end else if (o == 11) e = m[o] & 8'hF3;
        else if (f_readable(o)) e = m[o];
        else e = open_bus;
    endtask

    // Model of one write (R2, R8, R9, R11)
    task automatic m_write(input logic [15:0] a, input logic [7:0] d);
        int o;
        if (a < BASE || a > BASE + 16'd23) return;
        o = int'(a - BASE);
        if (o == 7) begin
            m[6] = m[7] - (m[6] >> 1);
            m[7] = m[7] >> 1;
        end else if (o == 10) m[8] = 8'h80;
        else if (f_stored(o)) m[o] = d;
        if (o == 9) midx = 0;
    endtask

    task automatic rd(input logic [15:0] a, input string req);
        logic [7:0] e;
        @(negedge clk);
        addr = a; rd_en = 1'b1; open_bus = 8'($urandom);
        m_read(a, e);
        @(negedge clk);
        rd_en = 1'b0;
        chk(req, rdata, e);
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        m_write(a, d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_time(input logic [7:0] h, input logic [7:0] mi, input logic [7:0] s);
        hour = h; minute = mi; second = s;
    endtask

    // Watchdog
    initial begin
        #(8 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] held;
        void'($urandom(32'd1234));
        for (int i = 0; i < 24; i++) m[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 rdata after reset", rdata, 8'h00);
        for (int i = 0; i < 24; i++) if (f_readable(i)) rd(BASE + 16'(i), "R1 register clear");

        // R2 plain storage
        wr(BASE + 16'd0, 8'hA5); rd(BASE + 16'd0, "R2 readback 2188");
        wr(BASE + 16'd15, 8'h3C); rd(BASE + 16'd15, "R2 readback 2197");
        wr(BASE + 16'd3, 8'h77); rd(BASE + 16'd3, "R3 write-only 218B");
        rd(16'h2187, "R3 below window");
        rd(16'h21A0, "R3 above window");
        rd(BASE + 16'd23, "R3 undecoded 219F");

        // R4 hold: value stays without reads
        wr(BASE + 16'd1, 8'h5A); rd(BASE + 16'd1, "R4 latency");
        held = rdata;
        repeat (4) @(negedge clk);
        chk("R4 hold", rdata, held);

        // R5/R6/R7 full frame plus wrap, time changes mid-frame
        set_time(8'd13, 8'd45, 8'd59);
        for (int i = 0; i < 20; i++) begin
            rd(BASE + 16'd10, "R5 R6 frame walk");
            if (i == 2) set_time(8'd7, 8'd8, 8'd9);
        end
        // R7: positions 2..3 of the second pass, then finish to position 10..12
        set_time(8'd23, 8'd0, 8'd1);
        for (int i = 0; i < 16; i++) rd(BASE + 16'd10, "R7 captured time");

        // R8 rewind mid-frame
        rd(BASE + 16'd10, "R5 step"); rd(BASE + 16'd10, "R5 step");
        wr(BASE + 16'd9, 8'h42);
        rd(BASE + 16'd9, "R8 link write-only");
        set_time(8'd11, 8'd22, 8'd33);
        for (int i = 0; i < 13; i++) rd(BASE + 16'd10, "R8 frame from start");

        // R9 port write forces status, frame untouched
        wr(BASE + 16'd10, 8'h55);
        rd(BASE + 16'd8, "R9 status forced");
        for (int i = 0; i < 6; i++) rd(BASE + 16'd10, "R9 frame unmoved");

        // R10 mask
        wr(BASE + 16'd11, 8'hFF); rd(BASE + 16'd11, "R10 mask bits 3 2");

        // R11 fold
        wr(BASE + 16'd6, 8'h64);
        wr(BASE + 16'd7, 8'hFF);
        rd(BASE + 16'd6, "R11 fold target");
        rd(BASE + 16'd7, "R11 fold trigger");
        wr(BASE + 16'd7, 8'h00);
        rd(BASE + 16'd6, "R11 second fold");

        // Random mix
        for (int k = 0; k < 3000; k++) begin
            logic [15:0] a;
            set_time(8'($urandom_range(23)), 8'($urandom_range(59)), 8'($urandom_range(59)));
            if ($urandom_range(9) == 0) a = 16'h2180 + 16'($urandom_range(40));
            else if ($urandom_range(2) == 0) a = BASE + 16'd10;
            else a = BASE + 16'($urandom_range(23));
            if ($urandom_range(3) == 0) wr(a, 8'($urandom));
            else rd(a, "R5 R3 R2 random mix");
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule